// File: doc/BRIEF.md
# Instruction Line-Fetch Request Generator

This block sits between an instruction-cache miss detector and a system bus. When a miss comes in, the block takes the miss address, the storage attribute of that address, and two software configuration bits. It turns them into one line-transfer request. The request carries four qualifiers: an aligned line address, a two-bit transfer-size code, a cacheable flag and an allocate hint.

A cacheable miss always asks for an eight-word line. For a non-cacheable miss, a configuration bit selects either a four-word line or an eight-word line. The address is aligned to the line that was chosen.

The request strobe stays high until the slave acknowledges the address. The qualifiers stay held for one more cycle after that acknowledge, and then they return to zero. The block accepts no new miss until the data transfer of the current request has been reported as complete, so only one request is outstanding at a time.

Top module: `line_fetch_req`

## Requirements
- R1: A synchronous active-high reset drives `reqValid`, `reqAddr`, `reqSize`, `reqCacheable` and `reqAllocate` to zero and sets `missReady` to 1, including when a request is in flight.
- R2: A cacheable miss produces `reqSize` = 2'b10 (eight words), `reqCacheable` = 1 and `reqAddr` equal to the miss address with its low five bits cleared.
- R3: A non-cacheable miss with `cfgNcLong` = 0 produces `reqSize` = 2'b01 (four words), `reqCacheable` = 0 and `reqAddr` with its low four bits cleared.
- R4: A non-cacheable miss with `cfgNcLong` = 1 produces `reqSize` = 2'b10, `reqCacheable` = 0 and `reqAddr` with its low five bits cleared.
- R5: `cfgNcLong` has no effect on a cacheable miss, which always yields `reqSize` = 2'b10.
- R6: `reqAllocate` is 1 only for a cacheable miss taken while `cfgNoAlloc` = 0. It is 0 for every non-cacheable miss and for every miss taken while `cfgNoAlloc` = 1.
- R7: A miss is accepted on a clock edge where `missValid` and `missReady` are both 1. `reqValid` is high in the cycle that follows. It stays high, with all qualifiers unchanged, for as long as `addrAck` stays low.
- R8: In the cycle after the edge that samples `addrAck` with `reqValid` high, `reqValid` is 0 and the qualifiers still hold their request values. From the cycle after that one, all qualifiers are zero.
- R9: `missReady` is 0 from acceptance until `xferDone` is sampled. A miss presented during that time starts no request.
- R10: `missReady` returns to 1 in the cycle after `xferDone` is sampled. `xferDone` is honoured in the hold cycle that follows the acknowledge or at any later point.
- R11: The address, attribute and configuration inputs are captured at acceptance. Changes to them while a request is outstanding do not alter the qualifiers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| missValid | input | 1 | A miss is being presented |
| missAddr | input | ADDR_W | Byte address of the missed instruction |
| missCacheable | input | 1 | Storage attribute of the miss address (1 = cacheable) |
| cfgNcLong | input | 1 | Non-cacheable misses fetch eight words when 1, four words when 0 |
| cfgNoAlloc | input | 1 | Cacheable lines are not to be written into the cache when 1 |
| missReady | output | 1 | A new miss can be accepted |
| addrAck | input | 1 | Slave acknowledges the request address |
| xferDone | input | 1 | Data transfer of the outstanding request has completed |
| reqValid | output | 1 | Request strobe |
| reqAddr | output | ADDR_W | Line-aligned request address |
| reqSize | output | 2 | Transfer size: 2'b01 four words, 2'b10 eight words, 2'b00 idle |
| reqCacheable | output | 1 | Request is cacheable |
| reqAllocate | output | 1 | Returned line may be written into the cache |

## Verification
The bench varies the slave's acknowledge delay from zero up to several cycles, so a design that dropped the strobe early or let a qualifier move while waiting is exposed. It also watches the single cycle after the acknowledge: a design that cleared the qualifiers together with the strobe fails there, and so does one that held them for too long. Addresses of all ones and addresses that are already aligned show whether the mask is four or five bits wide. Other cases cover a miss offered while a request is outstanding, a completion that arrives in the hold cycle, inputs that change after acceptance, and a reset in mid-request; each of these catches a design that starts a second request or captures its inputs late.

// File: rtl/line_fetch_pkg.sv
package line_fetch_pkg;

  localparam logic [1:0] SIZE_NONE  = 2'b00;
  localparam logic [1:0] SIZE_SHORT = 2'b01;
  localparam logic [1:0] SIZE_LONG  = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DRAIN = 2'd3
  } fetchState_t;

  typedef struct packed {
    logic load;
    logic clear;
  } dpCtl_t;

endpackage

// File: rtl/line_fetch_ctrl.sv
module line_fetch_ctrl
  import line_fetch_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   missValid,
  input  logic   addrAck,
  input  logic   xferDone,
  output logic   missReady,
  output logic   reqValid,
  output dpCtl_t dpCtl
);

  fetchState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (missValid) stateNext = ST_REQ;
      ST_REQ:   if (addrAck) stateNext = ST_HOLD;
      ST_HOLD:  stateNext = xferDone ? ST_IDLE : ST_DRAIN;
      ST_DRAIN: if (xferDone) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign missReady   = (state == ST_IDLE);
  assign reqValid    = (state == ST_REQ);
  assign dpCtl.load  = (state == ST_IDLE) && missValid;
  assign dpCtl.clear = (state == ST_HOLD);

  // R7: strobe persists until acknowledged
  a_r7_strobe_held: assert property (@(posedge clk) disable iff (rst)
    reqValid && !addrAck |=> reqValid);
  // R8: strobe drops the cycle after acknowledge
  a_r8_strobe_drop: assert property (@(posedge clk) disable iff (rst)
    reqValid && addrAck |=> !reqValid);
  // R9: no acceptance while a request is outstanding
  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    !missReady && !xferDone |=> !missReady || $past(state == ST_REQ));
  // R1: reset leaves the block ready with no strobe
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> missReady && !reqValid);

endmodule

// File: rtl/line_fetch_dp.sv
module line_fetch_dp
  import line_fetch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            dpCtl,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              missCacheable,
  input  logic              cfgNcLong,
  input  logic              cfgNoAlloc,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        reqSize,
  output logic              reqCacheable,
  output logic              reqAllocate
);

  localparam int SHORT_LSB = $clog2(4 * WORD_BYTES);
  localparam int LONG_LSB  = $clog2(8 * WORD_BYTES);

  logic              useLong;
  logic [ADDR_W-1:0] alignedAddr;

  assign useLong = missCacheable || cfgNcLong;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_align
    if (b < SHORT_LSB) begin : g_low
      assign alignedAddr[b] = 1'b0;
    end else if (b < LONG_LSB) begin : g_mid
      assign alignedAddr[b] = missAddr[b] & ~useLong;
    end else begin : g_high
      assign alignedAddr[b] = missAddr[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || dpCtl.clear) begin
      reqAddr      <= '0;
      reqSize      <= SIZE_NONE;
      reqCacheable <= 1'b0;
      reqAllocate  <= 1'b0;
    end else if (dpCtl.load) begin
      reqAddr      <= alignedAddr;
      reqSize      <= useLong ? SIZE_LONG : SIZE_SHORT;
      reqCacheable <= missCacheable;
      reqAllocate  <= missCacheable && !cfgNoAlloc;
    end
  end

  // R2: cacheable requests are always eight-word
  a_r2_cacheable_long: assert property (@(posedge clk) disable iff (rst)
    reqCacheable |-> reqSize == SIZE_LONG);
  // R3: four-word requests are quadword aligned
  a_r3_short_aligned: assert property (@(posedge clk) disable iff (rst)
    reqSize == SIZE_SHORT |-> reqAddr[SHORT_LSB-1:0] == '0);
  // R4: eight-word requests are line aligned
  a_r4_long_aligned: assert property (@(posedge clk) disable iff (rst)
    reqSize == SIZE_LONG |-> reqAddr[LONG_LSB-1:0] == '0);
  // R6: allocate implies cacheable
  a_r6_alloc_cacheable: assert property (@(posedge clk) disable iff (rst)
    reqAllocate |-> reqCacheable);

endmodule

// File: rtl/line_fetch_req.sv
module line_fetch_req
  import line_fetch_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              missCacheable,
  input  logic              cfgNcLong,
  input  logic              cfgNoAlloc,
  output logic              missReady,
  input  logic              addrAck,
  input  logic              xferDone,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        reqSize,
  output logic              reqCacheable,
  output logic              reqAllocate
);

  dpCtl_t dpCtl;

  line_fetch_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .missValid (missValid),
    .addrAck   (addrAck),
    .xferDone  (xferDone),
    .missReady (missReady),
    .reqValid  (reqValid),
    .dpCtl     (dpCtl)
  );

  line_fetch_dp #(
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .dpCtl         (dpCtl),
    .missAddr      (missAddr),
    .missCacheable (missCacheable),
    .cfgNcLong     (cfgNcLong),
    .cfgNoAlloc    (cfgNoAlloc),
    .reqAddr       (reqAddr),
    .reqSize       (reqSize),
    .reqCacheable  (reqCacheable),
    .reqAllocate   (reqAllocate)
  );

  // R7, R11: qualifiers frozen while waiting for the acknowledge
  a_r7_qual_stable: assert property (@(posedge clk) disable iff (rst)
    reqValid && !addrAck |=> $stable(reqAddr) && $stable(reqSize)
                             && $stable(reqCacheable) && $stable(reqAllocate));
  // R8: qualifiers survive into the cycle after the acknowledge
  a_r8_qual_hold: assert property (@(posedge clk) disable iff (rst)
    reqValid && addrAck |=> $stable(reqAddr) && $stable(reqSize)
                            && $stable(reqCacheable));
  // R7: a valid request always carries a defined size code
  a_r7_size_defined: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> (reqSize == SIZE_SHORT) || (reqSize == SIZE_LONG));
  // R1, R8: qualifiers are zero while idle
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    missReady |-> reqSize == SIZE_NONE && reqAddr == '0 && !reqCacheable && !reqAllocate);

endmodule

// File: tb/line_fetch_req_tb.sv
module line_fetch_req_tb;

  typedef struct packed {
    logic [31:0] addr;
    logic        cach;
    logic        ncLong;
    logic        noAlloc;
    logic [3:0]  delay;
    logic [31:0] expAddr;
    logic [1:0]  expSize;
    logic        expCach;
    logic        expAlloc;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1234, 1'b1, 1'b0, 1'b0, 4'd0, 32'h0000_1220, 2'b10, 1'b1, 1'b1},
    '{32'h8000_003C, 1'b1, 1'b1, 1'b1, 4'd2, 32'h8000_0020, 2'b10, 1'b1, 1'b0},
    '{32'h0000_1234, 1'b0, 1'b0, 1'b0, 4'd1, 32'h0000_1230, 2'b01, 1'b0, 1'b0},
    '{32'h0000_1234, 1'b0, 1'b1, 1'b0, 4'd3, 32'h0000_1220, 2'b10, 1'b0, 1'b0},
    '{32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 4'd0, 32'hFFFF_FFF0, 2'b01, 1'b0, 1'b0},
    '{32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 4'd5, 32'hFFFF_FFE0, 2'b10, 1'b1, 1'b1},
    '{32'h0000_0010, 1'b0, 1'b1, 1'b0, 4'd0, 32'h0000_0000, 2'b10, 1'b0, 1'b0},
    '{32'h0000_0018, 1'b0, 1'b0, 1'b0, 4'd1, 32'h0000_0010, 2'b01, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        missCacheable = 1'b0;
  logic        cfgNcLong = 1'b0;
  logic        cfgNoAlloc = 1'b0;
  logic        addrAck = 1'b0;
  logic        xferDone = 1'b0;
  logic        missReady, reqValid, reqCacheable, reqAllocate;
  logic [31:0] reqAddr;
  logic [1:0]  reqSize;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;

  line_fetch_req u_dut (
    .clk           (clk),
    .rst           (rst),
    .missValid     (missValid),
    .missAddr      (missAddr),
    .missCacheable (missCacheable),
    .cfgNcLong     (cfgNcLong),
    .cfgNoAlloc    (cfgNoAlloc),
    .missReady     (missReady),
    .addrAck       (addrAck),
    .xferDone      (xferDone),
    .reqValid      (reqValid),
    .reqAddr       (reqAddr),
    .reqSize       (reqSize),
    .reqCacheable  (reqCacheable),
    .reqAllocate   (reqAllocate)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkOut(input string req, input logic v, input logic rdy,
                          input logic [31:0] a, input logic [1:0] s,
                          input logic c, input logic al);
    check(req, "outputs", {reqValid, missReady, reqAddr, reqSize, reqCacheable, reqAllocate},
          {v, rdy, a, s, c, al});
  endtask

  task automatic present(input vec_t v);
    missValid     = 1'b1;
    missAddr      = v.addr;
    missCacheable = v.cach;
    cfgNcLong     = v.ncLong;
    cfgNoAlloc    = v.noAlloc;
    cyc();
    missValid     = 1'b0;
    missAddr      = ~v.addr;
    missCacheable = ~v.cach;
    cfgNcLong     = ~v.ncLong;
    cfgNoAlloc    = ~v.noAlloc;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkOut("R1", 1'b0, 1'b1, '0, 2'b00, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      present(v);
      // R2/R3/R4/R5/R6/R7/R11: strobe up with captured, aligned qualifiers
      checkOut("R7", 1'b1, 1'b0, v.expAddr, v.expSize, v.expCach, v.expAlloc);
      for (int d = 0; d < int'(v.delay); d++) begin
        cyc();
        checkOut("R11", 1'b1, 1'b0, v.expAddr, v.expSize, v.expCach, v.expAlloc);
      end
      addrAck = 1'b1;
      cyc();
      addrAck = 1'b0;
      checkOut("R8", 1'b0, 1'b0, v.expAddr, v.expSize, v.expCach, v.expAlloc);
      cyc();
      checkOut("R8", 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0);
      missValid = 1'b1;
      missAddr  = 32'hA5A5_A5A5;
      cyc();
      missValid = 1'b0;
      checkOut("R9", 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0);
      xferDone = 1'b1;
      cyc();
      xferDone = 1'b0;
      checkOut("R10", 1'b0, 1'b1, '0, 2'b00, 1'b0, 1'b0);
    end

    // R10: completion reported in the hold cycle
    present(VECS[2]);
    addrAck = 1'b1;
    cyc();
    addrAck  = 1'b0;
    xferDone = 1'b1;
    checkOut("R8", 1'b0, 1'b0, 32'h0000_1230, 2'b01, 1'b0, 1'b0);
    cyc();
    xferDone = 1'b0;
    checkOut("R10", 1'b0, 1'b1, '0, 2'b00, 1'b0, 1'b0);

    // R9: acknowledge while idle starts nothing
    addrAck = 1'b1;
    cyc();
    addrAck = 1'b0;
    checkOut("R9", 1'b0, 1'b1, '0, 2'b00, 1'b0, 1'b0);

    // R1: reset in mid-request
    present(VECS[5]);
    checkOut("R7", 1'b1, 1'b0, 32'hFFFF_FFE0, 2'b10, 1'b1, 1'b1);
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    checkOut("R1", 1'b0, 1'b1, '0, 2'b00, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule